// File: doc/BRIEF.md
# Register-Indirect Address Generator

This block turns one register-indirect memory reference into an effective address, the value the pointer register should take afterwards, and a flag that says whether that value must be written back. The caller supplies the current pointer, an optional unsigned byte displacement, an access form code and the identity of the pointer register (bank and index). One configuration word, held outside the block, gives each eligible pointer a 2-bit addressing mode and supplies one block-size field shared by all circular pointers.

Six access forms are supported: plain, post-increment, post-decrement, pre-increment, pre-decrement and offset. A pointer is in linear mode by default, and its arithmetic then wraps modulo 2^32. Only pointers 4 to 7 of either bank can be put in circular mode. In that mode a modified address stays inside an aligned power-of-two block: only its low N+1 bits change, where N is the block-size field.

A small two-state machine paces the response. In `ST_IDLE` no result is being shown. A request moves the machine to `ST_RESP` (transition `T_ACCEPT`), and the computed result is registered. In `ST_RESP` a further request keeps the machine there (`T_CHAIN`) and loads a new result. With no request it returns to `ST_IDLE` (`T_DRAIN`), and the registered result stays unchanged. Reset forces `ST_IDLE`.

Top module: `agu_addr_gen`

## Requirements
- R1: Form code 0 (plain) gives address = pointer, new pointer = pointer, write-back = 0.
- R2: Form codes 1 (post-increment) and 2 (post-decrement) give address = pointer, new pointer = pointer + d or pointer − d, and write-back = 1.
- R3: Form codes 3 (pre-increment) and 4 (pre-decrement) give address = new pointer = pointer + d or pointer − d, and write-back = 1.
- R4: Form code 5 (offset) gives address = pointer + d, new pointer = pointer, and write-back = 0.
- R5: When `req_has_disp` is 0, d is 1 whatever the value on `req_disp`. Otherwise d is `req_disp` zero-extended, in bytes.
- R6: Bank is selected by `req_side` (0 = A, 1 = B). Bank A pointer 4+k takes its mode from config bits [2k+1:2k], and bank B pointer 4+k takes its mode from bits [2k+9:2k+8], for k = 0 to 3. Mode 01 is circular and 00, 10 and 11 are linear. A pointer with an index outside 4 to 7 is always linear.
- R7: In circular mode the block size is 2^(N+1) bytes, where N = config bits [20:16]. Every modified address and pointer keeps the bits above bit N of the old pointer and takes its low N+1 bits from the sum or difference, so it wraps inside the block. With N = 31 the whole word changes.
- R8: A result appears on the outputs with `rsp_vld` = 1 on the clock edge after the request edge. With no request, `rsp_vld` is 0 and the other outputs hold their last values.
- R9: After reset `rsp_vld`, `rsp_addr`, `rsp_ptr` and `rsp_wb` are all 0.
- R10: Linear arithmetic wraps modulo 2^32 (pre-decrement of 0 by 1 gives 0xFFFFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access form code (0 to 5) |
| req_has_disp | input | 1 | 1 = use `req_disp`, 0 = d is 1 |
| req_disp | input | 15 | Unsigned byte displacement |
| req_side | input | 1 | Pointer bank, 0 = A, 1 = B |
| req_idx | input | 4 | Pointer index within the bank |
| req_ptr | input | 32 | Current pointer value |
| amc_cfg | input | 32 | Addressing-mode configuration word |
| rsp_vld | output | 1 | Result valid (machine in `ST_RESP`) |
| rsp_addr | output | 32 | Effective address |
| rsp_ptr | output | 32 | Updated pointer value |
| rsp_wb | output | 1 | Pointer write-back enable |

## Verification
On every cycle the assertions check the relation between each form code and the registered outputs one edge later: plain and offset never ask for write-back, post forms address the old pointer, and pre forms address the value they write back. They also check that a pointer outside the eligible range never selects circular mode, and that a circular update leaves the bits above the block unchanged. Only the bench scenarios show that the arithmetic values are right. This covers the default displacement, the placement of each bank's mode field, the reserved mode codes, the wrap at 64-byte and 128-byte blocks, the full-word block, the linear wrap through zero, and the reset and hold values.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AK_PLAIN    = 3'd0,
        AK_POST_INC = 3'd1,
        AK_POST_DEC = 3'd2,
        AK_PRE_INC  = 3'd3,
        AK_PRE_DEC  = 3'd4,
        AK_OFFSET   = 3'd5
    } agu_kind_e;

    typedef enum logic [1:0] {
        AM_LINEAR = 2'b00,
        AM_CIRC0  = 2'b01
    } agu_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } agu_state_e;

endpackage

// File: rtl/agu_mode_dec.sv
module agu_mode_dec #(
    parameter int ADDR_W     = 32,
    parameter int CFG_W      = 32,
    parameter int IDX_W      = 4,
    parameter int FIRST_CIRC = 4,
    parameter int NUM_CIRC   = 4,
    parameter int SIZE_LSB   = 16,
    parameter int SIZE_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_vld,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              side,
    input  logic [IDX_W-1:0]  idx,
    output logic              circ_en,
    output logic [ADDR_W-1:0] wrap_mask
);
    import agu_pkg::*;

    localparam int SLOTS     = 2 * NUM_CIRC;
    localparam int LAST_CIRC = FIRST_CIRC + NUM_CIRC - 1;
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0]  slot_circ;
    logic [SIZE_W-1:0] blk_n;
    logic              idx_ok;
    logic [SLOT_W-1:0] slot_sel;

    // one mode field per eligible pointer, bank A slots first
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_circ[s] = (cfg[2*s +: 2] == AM_CIRC0);
    end

    assign blk_n = cfg[SIZE_LSB +: SIZE_W];

    // block of 2^(N+1) bytes: bits 0..N may change
    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
        assign wrap_mask[b] = (32'(b) <= 32'(blk_n));
    end

    always_comb begin
        idx_ok   = (32'(idx) >= 32'(FIRST_CIRC)) && (32'(idx) <= 32'(LAST_CIRC));
        slot_sel = SLOT_W'(32'(side) * NUM_CIRC + 32'(idx) - 32'(FIRST_CIRC));
        circ_en  = idx_ok && slot_circ[slot_sel];
    end

    AST_LINEAR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld && ((32'(idx) < 32'(FIRST_CIRC)) || (32'(idx) > 32'(LAST_CIRC))) |-> !circ_en); // R6

endmodule

// File: rtl/agu_arith.sv
module agu_arith #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 15
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic              has_disp,
    input  logic [DISP_W-1:0] disp,
    input  logic [2:0]        kind,
    input  logic              circ_en,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] new_ptr,
    output logic              wb_en
);
    import agu_pkg::*;

    logic [ADDR_W-1:0] d_eff;
    logic [ADDR_W-1:0] sum_up;
    logic [ADDR_W-1:0] sum_dn;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] mod_up;
    logic [ADDR_W-1:0] mod_dn;

    always_comb begin
        d_eff     = has_disp ? ADDR_W'(disp) : ADDR_W'(1);
        sum_up    = ptr + d_eff;
        sum_dn    = ptr - d_eff;
        keep_mask = circ_en ? ~wrap_mask : '0;
        mod_up    = (ptr & keep_mask) | (sum_up & ~keep_mask);
        mod_dn    = (ptr & keep_mask) | (sum_dn & ~keep_mask);
    end

    always_comb begin
        unique case (kind)
            AK_POST_INC: begin eff_addr = ptr;    new_ptr = mod_up; wb_en = 1'b1; end
            AK_POST_DEC: begin eff_addr = ptr;    new_ptr = mod_dn; wb_en = 1'b1; end
            AK_PRE_INC:  begin eff_addr = mod_up; new_ptr = mod_up; wb_en = 1'b1; end
            AK_PRE_DEC:  begin eff_addr = mod_dn; new_ptr = mod_dn; wb_en = 1'b1; end
            AK_OFFSET:   begin eff_addr = mod_up; new_ptr = ptr;    wb_en = 1'b0; end
            default:     begin eff_addr = ptr;    new_ptr = ptr;    wb_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 15,
    parameter int IDX_W      = 4,
    parameter int CFG_W      = 32,
    parameter int FIRST_CIRC = 4,
    parameter int NUM_CIRC   = 4,
    parameter int SIZE_LSB   = 16,
    parameter int SIZE_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [2:0]        req_kind,
    input  logic              req_has_disp,
    input  logic [DISP_W-1:0] req_disp,
    input  logic              req_side,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [ADDR_W-1:0] req_ptr,
    input  logic [CFG_W-1:0]  amc_cfg,
    output logic              rsp_vld,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ADDR_W-1:0] rsp_ptr,
    output logic              rsp_wb
);
    import agu_pkg::*;

    agu_state_e        state_q, state_d;
    logic              circ_en;
    logic [ADDR_W-1:0] wrap_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] new_ptr;
    logic              wb_en;

    agu_mode_dec #(
        .ADDR_W(ADDR_W), .CFG_W(CFG_W), .IDX_W(IDX_W),
        .FIRST_CIRC(FIRST_CIRC), .NUM_CIRC(NUM_CIRC),
        .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .chk_vld(req_vld),
        .cfg(amc_cfg), .side(req_side), .idx(req_idx),
        .circ_en(circ_en), .wrap_mask(wrap_mask)
    );

    agu_arith #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_arith (
        .ptr(req_ptr), .has_disp(req_has_disp), .disp(req_disp),
        .kind(req_kind), .circ_en(circ_en), .wrap_mask(wrap_mask),
        .eff_addr(eff_addr), .new_ptr(new_ptr), .wb_en(wb_en)
    );

    // next state: T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_vld ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_vld ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers, loaded on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr <= '0;
            rsp_ptr  <= '0;
            rsp_wb   <= 1'b0;
        end else if (req_vld) begin
            rsp_addr <= eff_addr;
            rsp_ptr  <= new_ptr;
            rsp_wb   <= wb_en;
        end
    end

    assign rsp_vld = (state_q == ST_RESP);

    AST_PLAIN_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_kind == AK_PLAIN |=> !rsp_wb && rsp_addr == $past(req_ptr) && rsp_ptr == $past(req_ptr)); // R1
    AST_POST_OLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && (req_kind == AK_POST_INC || req_kind == AK_POST_DEC) |=> rsp_wb && rsp_addr == $past(req_ptr)); // R2
    AST_PRE_ADDR_IS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && (req_kind == AK_PRE_INC || req_kind == AK_PRE_DEC) |=> rsp_wb && rsp_addr == rsp_ptr); // R3
    AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_kind == AK_OFFSET |=> !rsp_wb && rsp_ptr == $past(req_ptr)); // R4
    AST_CIRC_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && circ_en |=> ((rsp_ptr ^ $past(req_ptr)) & ~$past(wrap_mask)) == '0
                            && ((rsp_addr ^ $past(req_ptr)) & ~$past(wrap_mask)) == '0); // R7
    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld && $stable(rsp_addr) && $stable(rsp_ptr) && $stable(rsp_wb)); // R8

endmodule

// File: tb/sim_agu_addr_gen.sv
`timescale 1ns/1ps
module sim_agu_addr_gen;

    localparam real CLK_PER = 8.0;

    typedef struct packed {
        logic [2:0]  kind;
        logic        hd;
        logic [14:0] disp;
        logic        side;
        logic [3:0]  idx;
        logic [31:0] ptr;
        logic [31:0] cfg;
        logic [31:0] ea;
        logic [31:0] ep;
        logic        ewb;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 15'h0008, 1'b0, 4'd1, 32'h0000_1000, 32'h0, 32'h0000_1000, 32'h0000_1000, 1'b0, 8'd1},  // R1
        '{3'd1, 1'b1, 15'h0004, 1'b0, 4'd2, 32'h0000_1000, 32'h0, 32'h0000_1000, 32'h0000_1004, 1'b1, 8'd2},  // R2
        '{3'd2, 1'b1, 15'h0004, 1'b1, 4'd0, 32'h0000_1000, 32'h0, 32'h0000_1000, 32'h0000_0FFC, 1'b1, 8'd2},  // R2
        '{3'd3, 1'b1, 15'h0010, 1'b0, 4'd9, 32'h0000_2000, 32'h0, 32'h0000_2010, 32'h0000_2010, 1'b1, 8'd3},  // R3
        '{3'd4, 1'b1, 15'h0010, 1'b1, 4'd3, 32'h0000_2000, 32'h0, 32'h0000_1FF0, 32'h0000_1FF0, 1'b1, 8'd3},  // R3
        '{3'd5, 1'b1, 15'h0020, 1'b0, 4'd0, 32'h0000_3000, 32'h0, 32'h0000_3020, 32'h0000_3000, 1'b0, 8'd4},  // R4
        '{3'd1, 1'b0, 15'h0040, 1'b0, 4'd8, 32'h0000_3000, 32'h0, 32'h0000_3000, 32'h0000_3001, 1'b1, 8'd5},  // R5
        '{3'd4, 1'b0, 15'h0000, 1'b1, 4'd2, 32'h0000_0000, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 8'd10}, // R10
        '{3'd1, 1'b1, 15'h0008, 1'b0, 4'd5, 32'h8000_003C, 32'h0005_0004, 32'h8000_003C, 32'h8000_0004, 1'b1, 8'd7}, // R7
        '{3'd4, 1'b1, 15'h0004, 1'b1, 4'd7, 32'h0000_1200, 32'h0006_4000, 32'h0000_127C, 32'h0000_127C, 1'b1, 8'd7}, // R7
        '{3'd1, 1'b1, 15'h0008, 1'b0, 4'd3, 32'h8000_003C, 32'h0005_FFFF, 32'h8000_003C, 32'h8000_0044, 1'b1, 8'd6}, // R6
        '{3'd1, 1'b1, 15'h0008, 1'b0, 4'd4, 32'h0000_003C, 32'h0005_0002, 32'h0000_003C, 32'h0000_0044, 1'b1, 8'd6}, // R6
        '{3'd1, 1'b1, 15'h0008, 1'b1, 4'd5, 32'h0000_003C, 32'h0005_0004, 32'h0000_003C, 32'h0000_0044, 1'b1, 8'd6}, // R6
        '{3'd5, 1'b1, 15'h0044, 1'b0, 4'd4, 32'h0000_0100, 32'h0005_0001, 32'h0000_0104, 32'h0000_0100, 1'b0, 8'd7}, // R7
        '{3'd1, 1'b1, 15'h0008, 1'b0, 4'd4, 32'hFFFF_FFFC, 32'h001F_0001, 32'hFFFF_FFFC, 32'h0000_0004, 1'b1, 8'd7}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [2:0]  req_kind = '0;
    logic        req_has_disp = 1'b0;
    logic [14:0] req_disp = '0;
    logic        req_side = 1'b0;
    logic [3:0]  req_idx = '0;
    logic [31:0] req_ptr = '0;
    logic [31:0] amc_cfg = '0;
    logic        rsp_vld;
    logic [31:0] rsp_addr;
    logic [31:0] rsp_ptr;
    logic        rsp_wb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PER / 2.0) clk = ~clk;

    agu_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
        .req_has_disp(req_has_disp), .req_disp(req_disp), .req_side(req_side),
        .req_idx(req_idx), .req_ptr(req_ptr), .amc_cfg(amc_cfg),
        .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_ptr(rsp_ptr), .rsp_wb(rsp_wb)
    );

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_a;
        logic [31:0] held_p;
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9", "rsp_vld", 32'(rsp_vld), 32'd0);
        check("R9", "rsp_addr", rsp_addr, 32'd0);
        check("R9", "rsp_ptr", rsp_ptr, 32'd0);
        check("R9", "rsp_wb", 32'(rsp_wb), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "idle rsp_vld", 32'(rsp_vld), 32'd0);

        // table walk, back-to-back requests
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].rq);
            req_vld      = 1'b1;
            req_kind     = VECS[i].kind;
            req_has_disp = VECS[i].hd;
            req_disp     = VECS[i].disp;
            req_side     = VECS[i].side;
            req_idx      = VECS[i].idx;
            req_ptr      = VECS[i].ptr;
            amc_cfg      = VECS[i].cfg;
            @(negedge clk);
            check("R8", "rsp_vld", 32'(rsp_vld), 32'd1);
            check(tag, $sformatf("vec %0d addr", i), rsp_addr, VECS[i].ea);
            check(tag, $sformatf("vec %0d ptr", i), rsp_ptr, VECS[i].ep);
            check(tag, $sformatf("vec %0d wb", i), 32'(rsp_wb), 32'(VECS[i].ewb));
        end

        // R8: no request -> outputs hold
        held_a = rsp_addr;
        held_p = rsp_ptr;
        req_vld = 1'b0;
        req_kind = 3'd3;
        req_ptr = 32'h1234_5678;
        @(negedge clk);
        check("R8", "hold rsp_vld", 32'(rsp_vld), 32'd0);
        check("R8", "hold addr", rsp_addr, held_a);
        check("R8", "hold ptr", rsp_ptr, held_p);
        @(negedge clk);
        check("R8", "hold addr 2", rsp_addr, held_a);

        // R5: displacement bus ignored without has_disp (pre-inc, 128-byte circ A6)
        req_vld = 1'b1; req_kind = 3'd3; req_has_disp = 1'b0; req_disp = 15'h7FFF;
        req_side = 1'b0; req_idx = 4'd6; req_ptr = 32'h0000_05FF; amc_cfg = 32'h0006_0010;
        @(negedge clk);
        check("R5", "no-disp circ addr", rsp_addr, 32'h0000_0580);
        check("R7", "no-disp circ ptr", rsp_ptr, 32'h0000_0580);

        // R9: reset in mid-run clears outputs
        req_vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "re-reset vld", 32'(rsp_vld), 32'd0);
        check("R9", "re-reset ptr", rsp_ptr, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule